// File: doc/BRIEF.md
# Lane-Partitioned 256-bit Vector Add/Subtract Unit

This execution unit takes one 32-bit instruction word and two 256-bit source operands that have already been read from the register file. It recognises ten add/subtract encodings and combines the operands lane by lane. The lane width selected by the opcode is 8, 16, 32, 64 or 128 bits. Each lane wraps modulo two to the power of its width. No carry or borrow ever crosses a lane boundary.

The sum or difference is captured in an output register together with the 5-bit destination register index. A valid flag or an illegal-opcode flag is raised one clock after the issue. The two source index fields of the instruction are the read addresses used before issue, so they do not affect this unit. Reset is asynchronous and active low, and the unit releases it internally on a clock edge.

Top module: `vec_addsub_unit`

## Requirements
- R1: `dest_idx` takes instruction bits [4:0] of an issued word; bits [9:5] and [14:10] name the registers behind `src_j` and `src_k` and have no effect here; the result is `src_j` op `src_k`.
- R2: With bits [31:20] = 12'b0111_0100_0000, the value of bits [19:15] selects an add: 5'b10100 gives 8-bit lanes, 5'b10101 gives 16-bit, 5'b10110 gives 32-bit and 5'b10111 gives 64-bit lanes.
- R3: With the same bits [31:20], bits [19:15] select a subtract: 5'b11000 gives 8-bit lanes, 5'b11001 gives 16-bit, 5'b11010 gives 32-bit and 5'b11011 gives 64-bit lanes.
- R4: With bits [31:20] = 12'b0111_0101_0010, bits [19:15] = 5'b11010 add and 5'b11011 subtract as two independent 128-bit lanes, bits [127:0] and [255:128].
- R5: Lane 0 sits at the least significant bits. Each lane wraps modulo 2^width, and carries and borrows stop at every lane boundary.
- R6: An issued word that matches none of the ten encodings sets `illegal_op`, keeps `result_valid` low and drives `result` to zero.
- R7: `result`, `dest_idx`, `result_valid` and `illegal_op` change exactly one rising clock edge after the issue cycle.
- R8: In a cycle without `issue_valid`, both flags go low on the next edge, while `result` and `dest_idx` keep their values.
- R9: While `rst_n` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | Instruction word is being issued this cycle |
| instr | input | 32 | Instruction word |
| src_j | input | 256 | First source operand (minuend for subtract) |
| src_k | input | 256 | Second source operand |
| result | output | 256 | Registered lane-wise result |
| dest_idx | output | 5 | Registered destination register index |
| result_valid | output | 1 | Result of a legal operation is present |
| illegal_op | output | 1 | Last issued word was not a recognised encoding |

## Verification
Every result and flag is due one rising edge after the issue cycle. The bench therefore drives each word just after a falling edge and reads all outputs at the next falling edge, half a period after the capturing edge. The idle checks read one falling edge later again, after an edge without issue, to confirm that the flags have dropped and the data has held. Reset checks sample a nanosecond after `rst_n` falls, with no clock edge in between, because the clear is asynchronous.

// File: rtl/vas_pkg.sv
package vas_pkg;

  // Lane width selector; numeric value n means 8 << n bits per lane.
  typedef enum logic [2:0] {
    LW_8   = 3'd0,
    LW_16  = 3'd1,
    LW_32  = 3'd2,
    LW_64  = 3'd3,
    LW_128 = 3'd4
  } lane_w_e;

  typedef struct packed {
    logic    legal;
    logic    sub;
    lane_w_e lw;
  } op_info_t;

  localparam logic [11:0] GRP_ELEM = 12'b0111_0100_0000;
  localparam logic [11:0] GRP_QUAD = 12'b0111_0101_0010;

endpackage

// File: rtl/vas_rst_sync.sv
module vas_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/vas_decode.sv
module vas_decode
  import vas_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic [31:0]      instr,
  output op_info_t         info,
  output logic [IDX_W-1:0] dst
);

  logic [11:0] grp;
  logic [4:0]  sel;

  assign grp = instr[31:20];
  assign sel = instr[19:15];
  assign dst = instr[IDX_W-1:0];

  always_comb begin
    info = '{legal: 1'b0, sub: 1'b0, lw: LW_8};
    if (grp == GRP_ELEM) begin
      // 101xx: add, 110xx: subtract; xx picks 8/16/32/64-bit lanes
      if (sel[4:2] == 3'b101 || sel[4:2] == 3'b110) begin
        info.legal = 1'b1;
        info.sub   = sel[3];
        info.lw    = lane_w_e'({1'b0, sel[1:0]});
      end
    end else if (grp == GRP_QUAD) begin
      if (sel[4:1] == 4'b1101) begin
        info.legal = 1'b1;
        info.sub   = sel[0];
        info.lw    = LW_128;
      end
    end
  end

endmodule

// File: rtl/vas_seg_adder.sv
module vas_seg_adder
  import vas_pkg::*;
#(
  parameter int DATA_W = 256,
  parameter int SEG_W  = 8
) (
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic              sub,
  input  lane_w_e           lw,
  output logic [DATA_W-1:0] sum
);

  localparam int NSEG  = DATA_W / SEG_W;
  localparam int IDX_W = (NSEG > 1) ? $clog2(NSEG) : 1;

  logic [IDX_W-1:0] lane_mask;   // segments per lane minus one
  logic [DATA_W-1:0] opb_eff;
  logic [NSEG-1:0]  seg_cin;
  logic [NSEG-2:0]  seg_cout;

  always_comb begin
    int lane_bits;
    lane_bits = 8 << int'(lw);
    lane_mask = IDX_W'((lane_bits / SEG_W) - 1);
  end

  assign opb_eff = sub ? ~opb : opb;

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    if (g == 0) begin : g_first
      assign seg_cin[g] = sub;
    end else begin : g_rest
      // a segment starting a lane restarts the chain with the subtract bit
      assign seg_cin[g] = ((IDX_W'(g) & lane_mask) == '0) ? sub : seg_cout[g-1];
    end

    if (g < NSEG - 1) begin : g_carry
      logic [SEG_W:0] part;
      assign part = {1'b0, opa[g*SEG_W +: SEG_W]} + {1'b0, opb_eff[g*SEG_W +: SEG_W]}
                  + {{SEG_W{1'b0}}, seg_cin[g]};
      assign sum[g*SEG_W +: SEG_W] = part[SEG_W-1:0];
      assign seg_cout[g]           = part[SEG_W];
    end else begin : g_top
      assign sum[g*SEG_W +: SEG_W] = opa[g*SEG_W +: SEG_W] + opb_eff[g*SEG_W +: SEG_W]
                                   + {{(SEG_W-1){1'b0}}, seg_cin[g]};
    end
  end

endmodule

// File: rtl/vec_addsub_unit.sv
module vec_addsub_unit
  import vas_pkg::*;
#(
  parameter int DATA_W = 256,
  parameter int SEG_W  = 8,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_valid,
  input  logic [31:0]       instr,
  input  logic [DATA_W-1:0] src_j,
  input  logic [DATA_W-1:0] src_k,
  output logic [DATA_W-1:0] result,
  output logic [IDX_W-1:0]  dest_idx,
  output logic              result_valid,
  output logic              illegal_op
);

  logic              rst_core_n;
  op_info_t          info;
  logic [IDX_W-1:0]  dst;
  logic [DATA_W-1:0] lane_sum;

  logic              res_en;
  logic [DATA_W-1:0] res_d, res_q;
  logic [IDX_W-1:0]  dst_q;
  logic              vld_d, vld_q;
  logic              ill_d, ill_q;

  // source index fields are consumed by the operand read ahead of issue
  logic unused_src_fields;
  assign unused_src_fields = ^instr[3*IDX_W-1:IDX_W];

  vas_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  vas_decode #(.IDX_W(IDX_W)) u_decode (
    .instr (instr),
    .info  (info),
    .dst   (dst)
  );

  vas_seg_adder #(.DATA_W(DATA_W), .SEG_W(SEG_W)) u_seg_adder (
    .opa (src_j),
    .opb (src_k),
    .sub (info.sub),
    .lw  (info.lw),
    .sum (lane_sum)
  );

  always_comb begin
    res_en = issue_valid;
    res_d  = info.legal ? lane_sum : '0;
    vld_d  = issue_valid & info.legal;
    ill_d  = issue_valid & ~info.legal;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      res_q <= '0;
      dst_q <= '0;
      vld_q <= 1'b0;
      ill_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      ill_q <= ill_d;
      if (res_en) begin
        res_q <= res_d;
        dst_q <= dst;
      end
    end
  end

  assign result       = res_q;
  assign dest_idx     = dst_q;
  assign result_valid = vld_q;
  assign illegal_op   = ill_q;

endmodule

// File: rtl/vas_checker.sv
module vas_checker #(
  parameter int DATA_W = 256,
  parameter int IDX_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              issue_valid,
  input logic [IDX_W-1:0]  instr_dst,
  input logic [DATA_W-1:0] result,
  input logic [IDX_W-1:0]  dest_idx,
  input logic              result_valid,
  input logic              illegal_op
);

  // R7: each issue yields exactly one of the two flags on the next edge
  a_r7_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |=> (result_valid ^ illegal_op));

  // R8: idle cycle clears both flags
  a_r8_idle_flags_low: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_valid |=> (!result_valid && !illegal_op));

  // R8: idle cycle keeps data and destination
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_valid |=> ($stable(result) && $stable(dest_idx)));

  // R6: an illegal word leaves a zero result
  a_r6_illegal_zero: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_op |-> (result == '0));

  // R1: destination index comes from the low field of the issued word
  a_r1_dest_field: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |=> (dest_idx == $past(instr_dst)));

endmodule

bind vec_addsub_unit vas_checker #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_vas_checker (
  .clk          (clk),
  .rst_n        (rst_core_n),
  .issue_valid  (issue_valid),
  .instr_dst    (instr[IDX_W-1:0]),
  .result       (result),
  .dest_idx     (dest_idx),
  .result_valid (result_valid),
  .illegal_op   (illegal_op)
);

// File: tb/test_vec_addsub_unit.sv
`timescale 1ns/1ps
module test_vec_addsub_unit;

  localparam int W = 256;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         issue_valid;
  logic [31:0]  instr;
  logic [W-1:0] src_j, src_k;
  logic [W-1:0] result;
  logic [4:0]   dest_idx;
  logic         result_valid, illegal_op;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  vec_addsub_unit i_vec_addsub_unit (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .instr(instr),
    .src_j(src_j), .src_k(src_k), .result(result), .dest_idx(dest_idx),
    .result_valid(result_valid), .illegal_op(illegal_op)
  );

  // opcode index: 0..3 add 8/16/32/64, 4 add 128, 5..8 sub 8/16/32/64, 9 sub 128
  localparam logic [16:0] OPS [10] = '{
    17'b0111_01000000_10100, 17'b0111_01000000_10101, 17'b0111_01000000_10110,
    17'b0111_01000000_10111, 17'b0111_01010010_11010,
    17'b0111_01000000_11000, 17'b0111_01000000_11001, 17'b0111_01000000_11010,
    17'b0111_01000000_11011, 17'b0111_01010010_11011 };
  localparam int OP_W [10] = '{8, 16, 32, 64, 128, 8, 16, 32, 64, 128};

  localparam logic [W-1:0] ONES = {W{1'b1}};

  // stimulus table: {op index, src_j, src_k}; expected from ref_calc
  localparam int NV = 12;
  localparam logic [4+2*W-1:0] VECS [NV] = '{
    {4'd0, ONES, {32{8'h01}}},
    {4'd1, ONES, {16{16'h0001}}},
    {4'd2, ONES, {8{32'h1}}},
    {4'd3, ONES, {4{64'h1}}},
    {4'd4, ONES, {2{128'h1}}},
    {4'd4, {128'h0, {128{1'b1}}}, {128'h0, 128'h1}},
    {4'd5, {W{1'b0}}, {32{8'h01}}},
    {4'd6, {16{16'h8000}}, {16{16'h0001}}},
    {4'd7, {W{1'b0}}, {W{1'b0}}},
    {4'd8, {64{4'h5}}, {64{4'hA}}},
    {4'd9, {W{1'b0}}, {2{128'h1}}},
    {4'd9, {128'h5, 128'h0}, {128'h3, 128'h1}} };

  function automatic logic [W-1:0] ref_calc(int lw, bit sub, logic [W-1:0] a, logic [W-1:0] b);
    logic [W-1:0] r;
    logic c, bb;
    r = '0;
    c = 1'b0;
    for (int n = 0; n < W; n++) begin
      if (n % lw == 0) c = sub;
      bb   = b[n] ^ sub;
      r[n] = a[n] ^ bb ^ c;
      c    = (a[n] & bb) | (a[n] & c) | (bb & c);
    end
    return r;
  endfunction

  function automatic string op_tag(int k);
    if (k == 4 || k == 9) return "R4";
    if (k < 4) return "R2";
    return "R3";
  endfunction

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(int k, logic [W-1:0] a, logic [W-1:0] b, logic [4:0] d, string extra);
    @(negedge clk);
    issue_valid = 1'b1;
    instr = {OPS[k], 5'(k + 3), 5'(k), d};
    src_j = a;
    src_k = b;
    @(negedge clk);
    issue_valid = 1'b0;
    chk({op_tag(k), extra, " result"}, result, ref_calc(OP_W[k], k >= 5, a, b));
    chk("R7 result_valid", W'(result_valid), W'(1));
    chk("R7 illegal_op", W'(illegal_op), W'(0));
    chk("R1 dest_idx", W'(dest_idx), W'(d));
  endtask

  task automatic run_illegal(logic [16:0] op);
    @(negedge clk);
    issue_valid = 1'b1;
    instr = {op, 15'h1234};
    src_j = ONES;
    src_k = ONES;
    @(negedge clk);
    issue_valid = 1'b0;
    chk("R6 illegal_op", W'(illegal_op), W'(1));
    chk("R6 result_valid", W'(result_valid), W'(0));
    chk("R6 result zero", result, '0);
  endtask

  initial begin
    rst_n = 1'b1;
    issue_valid = 1'b0;
    instr = '0;
    src_j = '0;
    src_k = '0;
    #1 rst_n = 1'b0;
    #1;
    chk("R9 reset result", result, '0);
    chk("R9 reset flags", W'({result_valid, illegal_op, dest_idx}), '0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // table walk (R5 boundary patterns inside)
    for (int v = 0; v < NV; v++) begin
      run_op(int'(VECS[v][4+2*W-1 -: 4]), VECS[v][2*W-1 -: W], VECS[v][W-1:0],
             5'(v + 7), " R5 table");
    end

    // random operands for every opcode
    for (int r = 0; r < 12; r++) begin
      for (int k = 0; k < 10; k++) begin
        logic [W-1:0] a, b;
        for (int q = 0; q < 8; q++) begin
          a[q*32 +: 32] = $urandom();
          b[q*32 +: 32] = $urandom();
        end
        run_op(k, a, b, 5'($urandom()), " random");
      end
    end

    // R6: unknown words, including near misses of legal encodings
    run_illegal(17'h0);
    run_illegal(17'b0111_01000000_11100);
    run_illegal(17'b0111_01010010_11001);
    run_illegal(17'b0111_01000001_10100);

    // R8: idle cycle holds data, drops flags; inputs change meanwhile
    run_op(3, {4{64'hFFFF_FFFF_FFFF_FFFF}}, {4{64'h2}}, 5'd21, " R8 setup");
    instr = {OPS[0], 15'h7FFF};
    src_j = ONES;
    src_k = '0;
    @(negedge clk);
    chk("R8 held result", result, {4{64'h1}});
    chk("R8 held dest_idx", W'(dest_idx), W'(21));
    chk("R8 flags low", W'({result_valid, illegal_op}), '0);

    // R9: asynchronous reset mid-run
    run_op(0, ONES, ONES, 5'd9, " R9 setup");
    #1 rst_n = 1'b0;
    #1;
    chk("R9 async result", result, '0);
    chk("R9 async flags", W'({result_valid, illegal_op, dest_idx}), '0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    run_op(9, {2{128'h10}}, {2{128'h11}}, 5'd30, " R5 after reset");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule